// File: doc/BRIEF.md
# In-Situ Storage Sensor Timing Sequencer

This block times an image sensor whose pixels each keep a small local charge store. When a train of particle bunches begins, the sequencer enters a slow capture phase. At a fixed interval it drives the array-wide photogate, and then the array-wide transfer gate, so that every pixel pushes its charge one slot deeper into its own store. Once the store holds a full set of frames, the train is over. The sequencer then uses the quiet gap that follows to read the array out, one row at a time and much faster than it captured.

For every stored pixel of the selected row, the readout runs a correlated double sample. First the shared reset gate is pulsed. Then the column converters are told to sample the reset level. Then the row's storage clock moves one charge packet onto the sense node. Last, the converters are told to sample the signal level. After the last pixel of the last row the sequencer emits a done pulse and waits for the next train. A train-start pulse that arrives while the sequencer is busy is dropped, and a sticky overrun flag records the event. Both rates come from the system clock through divider parameters.

Top module: `insitu_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no train-start, the sequencer is idle. Every gate, clock, select and strobe output is 0, and done and overrun are 0.
- R2: A train-start seen while idle begins a capture. The edge on which it is sampled is cycle 0 of the capture. In cycle k of the capture, pg_pulse is 1 exactly when k mod CAP_DIV equals CAP_DIV-2, and tg_pulse is 1 exactly when k mod CAP_DIV equals CAP_DIV-1. This repeats for DEPTH intervals, DEPTH*CAP_DIV cycles in all.
- R3: Readout is a series of slots, each RD_DIV cycles long. Each pixel takes four slots in a fixed order: reset, reference sample, shift, signal sample. Each output pulses only in the first cycle of its slot. rst_gate pulses in the reset slot. smp_strobe pulses in the reference slot with smp_is_sig=0. The storage clock pulses in the shift slot. smp_strobe pulses in the signal slot with smp_is_sig=1.
- R4: During readout, row_sel is one-hot. Bit r stays high for the 4*DEPTH slots of row r, and the rows are served from 0 upward to ROWS-1. Outside readout, row_sel is 0.
- R5: row_clk pulses only on the bit of the currently selected row, and only once per pixel.
- R6: One cycle after the last signal-sample slot of the last row ends, done is 1 for exactly one cycle and the sequencer is idle. A train-start in that cycle is accepted.
- R7: A train-start sampled during capture or readout has no effect on the timing of any output. It sets overrun, which then stays at 1 until reset.
- R8: The first reset-slot pulse of readout comes in the cycle right after the last tg_pulse of the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_start | input | 1 | Start of a bunch train, sampled each edge |
| pg_pulse | output | 1 | Array-wide photogate pulse |
| tg_pulse | output | 1 | Array-wide transfer gate pulse |
| row_sel | output | ROWS | One-hot row select during readout |
| row_clk | output | ROWS | Per-row storage clock pulse |
| rst_gate | output | 1 | Shared reset gate pulse |
| smp_strobe | output | 1 | Column converter sample strobe |
| smp_is_sig | output | 1 | Qualifies the strobe: 1 for the signal level, 0 for the reference level |
| done | output | 1 | One-cycle pulse at the end of readout |
| overrun | output | 1 | Sticky flag: a train-start arrived while busy |

## Verification
The interesting collisions are a train-start that lands in the very last readout cycle, and one that lands in the done cycle that follows. The first must be rejected and raise overrun. The second must be accepted as a fresh capture. The bench provokes both back to back by watching its own model's position in the run. It drives train_start high for exactly those two cycles and then compares every output, cycle by cycle, against a model that counts cycles from the moment a train is accepted.

// File: rtl/isq_pkg.sv
package isq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAP  = 2'd1,
    ST_READ = 2'd2
  } isq_state_e;

  // slot order inside one pixel readout
  typedef enum logic [1:0] {
    PH_RST  = 2'd0,
    PH_SREF = 2'd1,
    PH_SHFT = 2'd2,
    PH_SSIG = 2'd3
  } isq_phase_e;

  function automatic isq_phase_e next_phase(isq_phase_e p);
    return isq_phase_e'(p + 2'd1);
  endfunction

endpackage

// File: rtl/isq_divider.sv
module isq_divider #(
  parameter int LIMIT = 4,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          last
);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  assign last = (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (en)    cnt <= last ? '0 : cnt + 1'b1;
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST_V); // R2
endmodule

// File: rtl/isq_walker.sv
module isq_walker
  import isq_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int DEPTH = 20,
  parameter int RW    = 4,
  parameter int PW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output isq_phase_e    phase,
  output logic [RW-1:0] row_idx,
  output logic          walk_end
);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [PW-1:0] PIX_LAST = PW'(DEPTH - 1);

  logic [PW-1:0] pix;
  logic          pix_end;

  assign pix_end  = (phase == PH_SSIG) && (pix == PIX_LAST);
  assign walk_end = pix_end && (row_idx == ROW_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      phase   <= PH_RST;
      pix     <= '0;
      row_idx <= '0;
    end else if (step) begin
      phase <= next_phase(phase);
      if (phase == PH_SSIG)
        pix <= (pix == PIX_LAST) ? '0 : pix + 1'b1;
      if (pix_end)
        row_idx <= (row_idx == ROW_LAST) ? '0 : row_idx + 1'b1;
    end
  end

  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n) row_idx <= ROW_LAST); // R4
  AST_PIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) pix <= PIX_LAST); // R3
endmodule

// File: rtl/insitu_seq.sv
module insitu_seq
  import isq_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int DEPTH   = 20,
  parameter int CAP_DIV = 2500,
  parameter int RD_DIV  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            train_start,
  output logic            pg_pulse,
  output logic            tg_pulse,
  output logic [ROWS-1:0] row_sel,
  output logic [ROWS-1:0] row_clk,
  output logic            rst_gate,
  output logic            smp_strobe,
  output logic            smp_is_sig,
  output logic            done,
  output logic            overrun
);
  localparam int CCW = $clog2(CAP_DIV);
  localparam int RCW = $clog2(RD_DIV);
  localparam int RW  = (ROWS  > 1) ? $clog2(ROWS)  : 1;
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CCW-1:0] PG_AT      = CCW'(CAP_DIV - 2);
  localparam logic [PW-1:0]  FRAME_LAST = PW'(DEPTH - 1);

  isq_state_e     state;
  logic [PW-1:0]  frame;
  logic [CCW-1:0] cap_cnt;
  logic [RCW-1:0] rd_cnt;
  logic [RW-1:0]  row_idx;
  isq_phase_e     phase;

  // named events for the assertions
  logic cap_tick, rd_tick, walk_end, busy, start_ok, start_rej, slot_head, reading;

  assign busy      = (state != ST_IDLE);
  assign reading   = (state == ST_READ);
  assign start_ok  = train_start && !busy;
  assign start_rej = train_start && busy;
  assign slot_head = reading && (rd_cnt == '0);

  isq_divider #(.LIMIT(CAP_DIV), .CW(CCW)) u_cap_div (
    .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE), .en(state == ST_CAP),
    .cnt(cap_cnt), .last(cap_tick)
  );

  isq_divider #(.LIMIT(RD_DIV), .CW(RCW)) u_rd_div (
    .clk(clk), .rst_n(rst_n), .clr(!reading), .en(reading),
    .cnt(rd_cnt), .last(rd_tick)
  );

  isq_walker #(.ROWS(ROWS), .DEPTH(DEPTH), .RW(RW), .PW(PW)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(!reading), .step(rd_tick),
    .phase(phase), .row_idx(row_idx), .walk_end(walk_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      frame   <= '0;
      done    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_rej) overrun <= 1'b1;
      unique case (state)
        ST_IDLE: if (start_ok) begin
          state <= ST_CAP;
          frame <= '0;
        end
        ST_CAP: if (cap_tick) begin
          if (frame == FRAME_LAST) state <= ST_READ;
          else                     frame <= frame + 1'b1;
        end
        ST_READ: if (rd_tick && walk_end) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pg_pulse   = (state == ST_CAP) && (cap_cnt == PG_AT);
  assign tg_pulse   = (state == ST_CAP) && cap_tick;
  assign row_sel    = reading ? (ROWS'(1) << row_idx) : '0;
  assign row_clk    = (slot_head && phase == PH_SHFT) ? row_sel : '0;
  assign rst_gate   = slot_head && (phase == PH_RST);
  assign smp_strobe = slot_head && (phase == PH_SREF || phase == PH_SSIG);
  assign smp_is_sig = slot_head && (phase == PH_SSIG);

  AST_TG_AFTER_PG: assert property (@(posedge clk) disable iff (!rst_n) pg_pulse |=> tg_pulse); // R2
  AST_CAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (pg_pulse || tg_pulse) |-> (row_sel == '0 && !smp_strobe)); // R3
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(row_sel)); // R4
  AST_SHIFT_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n) (|row_clk) |-> ($onehot(row_clk) && (row_clk & ~row_sel) == '0)); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (row_sel == '0 && !rst_gate)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R7
  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (train_start && busy) |=> overrun); // R7
  AST_READ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) (tg_pulse && frame == FRAME_LAST) |=> rst_gate); // R8
endmodule

// File: tb/insitu_seq_test.sv
module insitu_seq_test;
  localparam int ROWS = 3, DEPTH = 4, CD = 6, RD = 3;
  localparam int CAPN  = DEPTH * CD;
  localparam int TOTAL = CAPN + ROWS * DEPTH * 4 * RD;

  logic clk = 1'b0, rst_n = 1'b0, train_start = 1'b0;
  logic pg_pulse, tg_pulse, rst_gate, smp_strobe, smp_is_sig, done, overrun;
  logic [ROWS-1:0] row_sel, row_clk;

  int checks = 0, failures = 0, done_seen = 0;
  bit m_busy = 0, m_done = 0, m_ovr = 0;
  int m_t = 0;

  always #10 clk = ~clk;

  insitu_seq #(.ROWS(ROWS), .DEPTH(DEPTH), .CAP_DIV(CD), .RD_DIV(RD)) uut (
    .clk(clk), .rst_n(rst_n), .train_start(train_start),
    .pg_pulse(pg_pulse), .tg_pulse(tg_pulse), .row_sel(row_sel), .row_clk(row_clk),
    .rst_gate(rst_gate), .smp_strobe(smp_strobe), .smp_is_sig(smp_is_sig),
    .done(done), .overrun(overrun)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: counts cycles since acceptance
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_ovr = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (train_start) m_ovr = 1;
        if (m_t == TOTAL - 1) begin m_busy = 0; m_done = 1; end
        else m_t++;
      end else if (train_start) begin
        m_busy = 1; m_t = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int e_pg, e_tg, e_rst, e_stb, e_sig, e_sel, e_clk;
      e_pg = 0; e_tg = 0; e_rst = 0; e_stb = 0; e_sig = 0; e_sel = 0; e_clk = 0;
      if (m_busy && m_t < CAPN) begin
        e_pg = (m_t % CD == CD - 2);
        e_tg = (m_t % CD == CD - 1);
      end else if (m_busy) begin
        int u, slot, ph, row;
        u = m_t - CAPN; slot = u / RD; ph = slot % 4; row = slot / (4 * DEPTH);
        e_sel = 1 << row;
        if (u % RD == 0) begin
          e_rst = (ph == 0);
          e_stb = (ph == 1 || ph == 3);
          e_sig = (ph == 3);
          e_clk = (ph == 2) ? (1 << row) : 0;
        end
        if (u == 0) chk("R8 first reset after capture", int'(rst_gate), 1);
      end
      chk("R2 pg_pulse", int'(pg_pulse), e_pg);
      chk("R2 tg_pulse", int'(tg_pulse), e_tg);
      chk("R3 rst_gate", int'(rst_gate), e_rst);
      chk("R3 smp_strobe", int'(smp_strobe), e_stb);
      chk("R3 smp_is_sig", int'(smp_is_sig), e_sig);
      chk("R4 row_sel", int'(row_sel), e_sel);
      chk("R5 row_clk", int'(row_clk), e_clk);
      chk("R6 done", int'(done), int'(m_done));
      chk("R7 overrun", int'(overrun), int'(m_ovr));
      if (done) done_seen++;
    end
  end

  task automatic pulse_start();
    @(negedge clk) train_start = 1'b1;
    @(negedge clk) train_start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 outputs idle", int'({pg_pulse, tg_pulse, rst_gate, smp_strobe, smp_is_sig, done}), 0);
    chk("R1 row lines", int'({row_sel, row_clk}), 0);
    chk("R1 overrun", int'(overrun), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // run 1 with rejected starts in capture and in readout (R7)
    pulse_start();
    repeat (8) @(negedge clk);
    train_start = 1'b1; @(negedge clk) train_start = 1'b0;
    repeat (40) @(negedge clk);
    train_start = 1'b1; @(negedge clk) train_start = 1'b0;
    wait_done();
    repeat (3) @(negedge clk);
    // run 2: start in final readout cycle is rejected, start in done cycle accepted (R6, R7)
    pulse_start();
    while (!(m_busy && m_t == TOTAL - 1)) @(negedge clk);
    train_start = 1'b1;
    @(negedge clk);
    chk("R6 done with start", int'(done), 1);
    @(negedge clk) train_start = 1'b0;
    chk("R6 restart accepted", int'(m_busy), 1);
    wait_done();
    repeat (4) @(negedge clk);
    chk("R6 done count", done_seen, 3);
    chk("R7 overrun held", int'(overrun), 1);
    // R1: reset clears overrun
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 overrun after reset", int'(overrun), 0);
    chk("R1 row_sel after reset", int'(row_sel), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule